// File: doc/BRIEF.md
# Channel Command Word Sequencer

This block runs a channel program for one attached device. A start strobe gives it the address of the first command word, and the block then reads 64-bit command words from memory one at a time. It hands each command to the device through a command handshake and waits for the device to report end status. It decides what to fetch next from the word's chaining flags and from that status.

Data chaining keeps the device on the same operation and supplies only a new buffer address and count. Command chaining moves on to a new operation. A transfer-in-channel word redirects fetching and issues nothing to the device. When the device reports status modifier on a command-chained command, the block skips one word, which lets a search loop step past its own branch.

The program ends on a word that has no chaining, or on an exception. At the end the block raises a one-cycle interrupt and holds an end code. A load-start variant runs an implied read at address 0 and then continues the program at address 8.

Top module: `ccw_seq`

## Requirements
- R1: After reset, and whenever it is not busy, the block issues no memory read and no device command. `busy_o`, `irq_o` and `end_code_o` are 0. Every memory read address is a multiple of 8.
- R2: When a program ends, `irq_o` pulses for exactly one cycle and `busy_o` falls in that same cycle. `end_code_o` then holds the result until the next start: 0 normal, 1 device error, 2 incorrect length, 3 program check.
- R3: Word layout: bits 63:56 opcode, 55:32 data address, 31:24 flags, 23:16 reserved, 15:0 byte count. The flag bits are 31 data chain, 30 command chain, 29 suppress length, 28 skip and 27 PCI. While command chaining, the words execute at consecutive addresses 8 bytes apart. A held device command keeps its fields stable until it is accepted.
- R4: A data-chained word supplies only a new address and count. The device sees the previous opcode with `dev_cont_o`=1, and the word's own opcode is ignored.
- R5: A word whose opcode low nibble is 8 is a transfer-in-channel. It issues no device command, and fetching resumes at its data address with bits 2:0 cleared.
- R6: Status modifier on the end of a command-chained command makes the next fetch at the current address plus 16 instead of plus 8.
- R7: A transfer-in-channel that lands directly on another transfer-in-channel ends the program with program check. So does any word with a nonzero reserved byte or a nonzero flag bit 26:24.
- R8: A nonzero residual count at the end of a command that is not data-chained ends the program with incorrect length, unless suppress length is set. If suppress length is set, chaining continues.
- R9: A device error at the end of a command ends the program with device error, whatever the chaining flags say.
- R10: A word with the PCI flag pulses `pci_o` once, and the program continues.
- R11: A start with `ipl_i`=1 issues opcode 0x02 with address 0 and count 24 without fetching from memory, command chaining assumed, and then fetches address 8.
- R12: A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| ipl_i | input | 1 | Start with the implied load read |
| start_addr_i | input | 24 | First command word address |
| mem_rd_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | 24 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Command word |
| dev_cmd_valid_o | output | 1 | Device command valid |
| dev_cmd_ready_i | input | 1 | Device accepts command |
| dev_op_o | output | 8 | Command opcode |
| dev_addr_o | output | 24 | Data address |
| dev_cnt_o | output | 16 | Byte count |
| dev_cont_o | output | 1 | Data-chained continuation |
| dev_skip_o | output | 1 | Skip data transfer flag |
| dev_end_i | input | 1 | Device end status valid |
| dev_resid_i | input | 16 | Residual count |
| dev_sm_i | input | 1 | Status modifier |
| dev_err_i | input | 1 | Device error |
| busy_o | output | 1 | Program running |
| irq_o | output | 1 | End interrupt pulse |
| pci_o | output | 1 | Program-controlled interrupt pulse |
| end_code_o | output | 2 | End code |

## Verification
The assertions check on every cycle that the block stays quiet when idle, that read addresses are aligned, that the end interrupt lasts one cycle, that a held command stays stable, and that PCI pulses occur only while busy. The bench scenarios cover what depends on whole programs: the order and content of the issued commands under data and command chaining, branch targets, the status-modifier skip in a search loop, the branch-to-branch, reserved-bit, length and device-error endings, the load-start sequence, and a start strobe ignored mid-program.

// File: rtl/ccw_pkg.sv
package ccw_pkg;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int OP_W   = 8;
  localparam int WORD_W = 64;
  localparam int WORD_BYTES = 8;
  localparam logic [OP_W-1:0] OP_IPL_READ = 8'h02;
  localparam logic [CNT_W-1:0] IPL_CNT    = 16'd24;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic              dc;
    logic              cc;
    logic              sli;
    logic              skip;
    logic              pci;
    logic [CNT_W-1:0]  cnt;
    logic              is_tic;
    logic              bad;
  } ccw_t;

  typedef enum logic [1:0] {
    END_OK   = 2'd0,
    END_DEV  = 2'd1,
    END_LEN  = 2'd2,
    END_PROG = 2'd3
  } end_t;
endpackage

// File: rtl/ccw_decode.sv
module ccw_decode
  import ccw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output ccw_t              ccw_o
);
  always_comb begin
    ccw_o.op     = word_i[63:56];
    ccw_o.addr   = word_i[55:32];
    ccw_o.dc     = word_i[31];
    ccw_o.cc     = word_i[30];
    ccw_o.sli    = word_i[29];
    ccw_o.skip   = word_i[28];
    ccw_o.pci    = word_i[27];
    ccw_o.cnt    = word_i[15:0];
    ccw_o.is_tic = (word_i[59:56] == 4'h8);
    ccw_o.bad    = (|word_i[26:24]) | (|word_i[23:16]);
  end
endmodule

// File: rtl/ccw_next_addr.sv
module ccw_next_addr
  import ccw_pkg::*;
(
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              skip_one_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  assign next_o = skip_one_i ? pc_i + (STEP << 1) : pc_i + STEP;
endmodule

// File: rtl/ccw_seq.sv
module ccw_seq
  import ccw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ipl_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              dev_cmd_valid_o,
  input  logic              dev_cmd_ready_i,
  output logic [OP_W-1:0]   dev_op_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [CNT_W-1:0]  dev_cnt_o,
  output logic              dev_cont_o,
  output logic              dev_skip_o,
  input  logic              dev_end_i,
  input  logic [CNT_W-1:0]  dev_resid_i,
  input  logic              dev_sm_i,
  input  logic              dev_err_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              pci_o,
  output logic [1:0]        end_code_o
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_EXEC, S_ISSUE, S_DEV} state_t;

  state_t            state_q;
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] pc_q;
  logic              last_tic_q, cont_q, cur_dc_q, cur_cc_q, cur_sli_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              skip_q, irq_q, pci_q;
  end_t              end_q;
  ccw_t              ccw;
  logic [ADDR_W-1:0] pc_next;

  ccw_decode u_dec (.word_i(word_q), .ccw_o(ccw));
  ccw_next_addr u_nxt (.pc_i(pc_q), .skip_one_i(dev_sm_i), .next_o(pc_next));

  localparam logic [WORD_W-1:0] IPL_WORD =
    {OP_IPL_READ, {ADDR_W{1'b0}}, 8'h60, 8'h00, IPL_CNT};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; word_q <= '0; pc_q <= '0; last_tic_q <= 1'b0;
      cont_q <= 1'b0; cur_dc_q <= 1'b0; cur_cc_q <= 1'b0; cur_sli_q <= 1'b0;
      op_q <= '0; daddr_q <= '0; cnt_q <= '0; skip_q <= 1'b0;
      irq_q <= 1'b0; pci_q <= 1'b0; end_q <= END_OK;
    end else begin
      irq_q <= 1'b0;
      pci_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          end_q <= END_OK; last_tic_q <= 1'b0; cont_q <= 1'b0;
          if (ipl_i) begin
            word_q <= IPL_WORD; pc_q <= '0; state_q <= S_EXEC;
          end else begin
            pc_q <= {start_addr_i[ADDR_W-1:3], 3'b000}; state_q <= S_FETCH;
          end
        end
        S_FETCH: state_q <= S_WAIT;
        S_WAIT: if (mem_rvalid_i) begin
          word_q <= mem_rdata_i; state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (ccw.bad || (ccw.is_tic && last_tic_q)) begin
            end_q <= END_PROG; irq_q <= 1'b1; state_q <= S_IDLE;
          end else if (ccw.is_tic) begin
            pc_q <= {ccw.addr[ADDR_W-1:3], 3'b000};
            last_tic_q <= 1'b1; state_q <= S_FETCH;
          end else begin
            last_tic_q <= 1'b0;
            if (!cont_q) op_q <= ccw.op;
            daddr_q <= ccw.addr; cnt_q <= ccw.cnt; skip_q <= ccw.skip;
            cur_dc_q <= ccw.dc; cur_cc_q <= ccw.cc; cur_sli_q <= ccw.sli;
            pci_q <= ccw.pci;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: if (dev_cmd_ready_i) state_q <= S_DEV;
        S_DEV: if (dev_end_i) begin
          if (dev_err_i) begin
            end_q <= END_DEV; irq_q <= 1'b1; state_q <= S_IDLE;
          end else if (cur_dc_q) begin
            pc_q <= pc_q + ADDR_W'(WORD_BYTES); cont_q <= 1'b1; state_q <= S_FETCH;
          end else if (dev_resid_i != '0 && !cur_sli_q) begin
            end_q <= END_LEN; irq_q <= 1'b1; state_q <= S_IDLE;
          end else if (cur_cc_q) begin
            pc_q <= pc_next; cont_q <= 1'b0; state_q <= S_FETCH;
          end else begin
            end_q <= END_OK; irq_q <= 1'b1; state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_o        = (state_q == S_FETCH);
  assign mem_addr_o      = pc_q;
  assign dev_cmd_valid_o = (state_q == S_ISSUE);
  assign dev_op_o        = op_q;
  assign dev_addr_o      = daddr_q;
  assign dev_cnt_o       = cnt_q;
  assign dev_cont_o      = cont_q;
  assign dev_skip_o      = skip_q;
  assign busy_o          = (state_q != S_IDLE);
  assign irq_o           = irq_q;
  assign pci_o           = pci_q;
  assign end_code_o      = end_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_rd_o && !dev_cmd_valid_o)) else $error("idle activity"); // R1
  AST_RD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mem_addr_o[2:0] == 3'b000)) else $error("unaligned read"); // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o) else $error("irq width"); // R2
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o) else $error("irq while busy"); // R2
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_cmd_valid_o && !dev_cmd_ready_i) |=>
      (dev_cmd_valid_o && $stable(dev_op_o) && $stable(dev_addr_o) && $stable(dev_cnt_o)))
    else $error("cmd unstable"); // R3
  AST_PCI_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_o |-> busy_o) else $error("pci idle"); // R10
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, dev_cmd_valid_o, irq_o})) else $error("overlap"); // R1
endmodule

// File: tb/ccw_seq_tb.sv
module ccw_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] F_DC = 8'h80, F_CC = 8'h40, F_SLI = 8'h20, F_PCI = 8'h08;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ipl = 1'b0;
  logic [23:0] saddr = '0;
  logic mem_rd, rvalid;
  logic [23:0] maddr;
  logic [63:0] rdata;
  logic cval, cont, skip;
  logic [7:0] dop;
  logic [23:0] daddr;
  logic [15:0] dcnt;
  logic dend, dsm, derr;
  logic [15:0] dresid;
  logic busy, irq, pci;
  logic [1:0] ecode;

  int tests = 0, fails = 0;
  logic [63:0] mem [32];
  logic [15:0] r_resid [16];
  logic r_sm [16], r_err [16];
  logic [7:0] l_op [16];
  logic [23:0] l_addr [16];
  logic [15:0] l_cnt [16];
  logic l_cont [16];
  int ncmd, nirq, npci, nrd_zero, cur, dly;
  logic clr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccw_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ipl_i(ipl), .start_addr_i(saddr),
    .mem_rd_o(mem_rd), .mem_addr_o(maddr), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .dev_cmd_valid_o(cval), .dev_cmd_ready_i(1'b1), .dev_op_o(dop), .dev_addr_o(daddr),
    .dev_cnt_o(dcnt), .dev_cont_o(cont), .dev_skip_o(skip), .dev_end_i(dend),
    .dev_resid_i(dresid), .dev_sm_i(dsm), .dev_err_i(derr),
    .busy_o(busy), .irq_o(irq), .pci_o(pci), .end_code_o(ecode));

  always @(posedge clk) begin
    rvalid <= mem_rd;
    rdata  <= mem[maddr[7:3]];
  end

  always @(posedge clk) begin
    if (clr) begin
      ncmd <= 0; nirq <= 0; npci <= 0; nrd_zero <= 0; dly <= 0; dend <= 1'b0;
    end else begin
      dend <= 1'b0;
      if (irq) nirq <= nirq + 1;
      if (pci) npci <= npci + 1;
      if (mem_rd && maddr == 24'h0) nrd_zero <= nrd_zero + 1;
      if (cval && ncmd < 16) begin
        l_op[ncmd] <= dop; l_addr[ncmd] <= daddr; l_cnt[ncmd] <= dcnt; l_cont[ncmd] <= cont;
        cur <= ncmd; ncmd <= ncmd + 1; dly <= 3;
      end else if (dly != 0) begin
        dly <= dly - 1;
        if (dly == 1) begin
          dend <= 1'b1; dresid <= r_resid[cur]; dsm <= r_sm[cur]; derr <= r_err[cur];
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    fails++; tests++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [63:0] w(input logic [7:0] op, input logic [23:0] a,
                                    input logic [7:0] f, input logic [15:0] c);
    return {op, a, f, 8'h00, c};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup();
    for (int i = 0; i < 32; i++) mem[i] = w(8'hFF, 24'h0, 8'h07, 16'h0);
    for (int i = 0; i < 16; i++) begin r_resid[i] = '0; r_sm[i] = 1'b0; r_err[i] = 1'b0; end
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic run(input logic [23:0] a, input logic is_ipl, input logic poke);
    @(negedge clk); start = 1'b1; ipl = is_ipl; saddr = a;
    @(negedge clk); start = 1'b0; ipl = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1; saddr = 24'h0C0; @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 400 && nirq == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_cmd(input string req, input int i, input logic [7:0] op,
                         input logic [23:0] a, input logic [15:0] c, input logic k);
    chk(req, {l_op[i], l_addr[i], l_cnt[i], 7'd0, l_cont[i]}, {op, a, c, 7'd0, k});
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R2 reset irq/code", {irq, ecode}, 0);
    chk("R1 reset quiet", {mem_rd, cval}, 0);
  endtask

  task automatic t_cmd_chain();
    setup();
    mem[2] = w(8'h01, 24'h1000, F_CC, 16'd4);
    mem[3] = w(8'h03, 24'h2000, F_CC, 16'd8);
    mem[4] = w(8'h02, 24'h3000, 8'h00, 16'd2);
    run(24'h010, 0, 0);
    chk("R3 count", ncmd, 3);
    chk_cmd("R3 cmd0", 0, 8'h01, 24'h1000, 16'd4, 0);
    chk_cmd("R3 cmd1", 1, 8'h03, 24'h2000, 16'd8, 0);
    chk_cmd("R3 cmd2", 2, 8'h02, 24'h3000, 16'd2, 0);
    chk("R2 ok end", {busy, ecode}, 0);
    chk("R2 one irq", nirq, 1);
  endtask

  task automatic t_data_chain();
    setup();
    mem[0] = w(8'h02, 24'h0400, F_DC, 16'd16);
    mem[1] = w(8'h77, 24'h0800, 8'h00, 16'd32);
    run(24'h000, 0, 0);
    chk("R4 count", ncmd, 2);
    chk_cmd("R4 first", 0, 8'h02, 24'h0400, 16'd16, 0);
    chk_cmd("R4 cont", 1, 8'h02, 24'h0800, 16'd32, 1);
    chk("R4 end", ecode, 0);
  endtask

  task automatic t_tic();
    setup();
    mem[0] = w(8'h01, 24'h0100, F_CC, 16'd1);
    mem[1] = w(8'h08, 24'h0045, 8'h00, 16'd0);
    mem[8] = w(8'h06, 24'h0200, 8'h00, 16'd1);
    run(24'h000, 0, 0);
    chk("R5 count", ncmd, 2);
    chk_cmd("R5 target", 1, 8'h06, 24'h0200, 16'd1, 0);
    chk("R5 end", ecode, 0);
  endtask

  task automatic t_search_loop();
    setup();
    mem[4] = w(8'h07, 24'h0010, F_CC, 16'd0);
    mem[5] = w(8'h29, 24'h0500, F_CC, 16'd5);
    mem[6] = w(8'h08, 24'h0028, 8'h00, 16'd0);
    mem[7] = w(8'h06, 24'h0600, 8'h00, 16'd0);
    r_sm[2] = 1'b1;
    run(24'h020, 0, 0);
    chk("R6 count", ncmd, 4);
    chk_cmd("R6 search again", 2, 8'h29, 24'h0500, 16'd5, 0);
    chk_cmd("R6 read after skip", 3, 8'h06, 24'h0600, 16'd0, 0);
    chk("R6 end", ecode, 0);
  endtask

  task automatic t_tic_tic();
    setup();
    mem[0] = w(8'h08, 24'h0008, 8'h00, 16'd0);
    mem[1] = w(8'h08, 24'h0010, 8'h00, 16'd0);
    run(24'h000, 0, 0);
    chk("R7 tic-tic code", ecode, 3);
    chk("R7 tic-tic no cmd", ncmd, 0);
    setup();
    mem[0] = w(8'h01, 24'h0, F_CC, 16'd1);
    mem[1] = {w(8'h02, 24'h0, 8'h00, 16'd1)} | 64'h0000_0000_0001_0000;
    run(24'h000, 0, 0);
    chk("R7 reserved code", {ncmd[3:0], ecode}, {4'd1, 2'd3});
  endtask

  task automatic t_length();
    setup();
    mem[0] = w(8'h02, 24'h0, F_CC, 16'd10);
    mem[1] = w(8'h02, 24'h0, 8'h00, 16'd10);
    r_resid[0] = 16'd5;
    run(24'h000, 0, 0);
    chk("R8 length code", ecode, 2);
    chk("R8 stops", ncmd, 1);
    setup();
    mem[0] = w(8'h02, 24'h0, F_CC | F_SLI, 16'd10);
    mem[1] = w(8'h02, 24'h0, 8'h00, 16'd10);
    r_resid[0] = 16'd5;
    run(24'h000, 0, 0);
    chk("R8 suppressed", {ncmd[3:0], ecode}, {4'd2, 2'd0});
  endtask

  task automatic t_dev_err();
    setup();
    mem[0] = w(8'h01, 24'h0, F_CC, 16'd1);
    mem[1] = w(8'h01, 24'h0, 8'h00, 16'd1);
    r_err[0] = 1'b1;
    run(24'h000, 0, 0);
    chk("R9 code", {ncmd[3:0], ecode}, {4'd1, 2'd1});
  endtask

  task automatic t_pci();
    setup();
    mem[0] = w(8'h01, 24'h0, F_CC | F_PCI, 16'd1);
    mem[1] = w(8'h01, 24'h0, 8'h00, 16'd1);
    run(24'h000, 0, 0);
    chk("R10 one pci", npci, 1);
    chk("R10 continues", {ncmd[3:0], ecode}, {4'd2, 2'd0});
  endtask

  task automatic t_ipl();
    setup();
    mem[0] = w(8'h08, 24'h0000, 8'h00, 16'd0);
    mem[1] = w(8'h02, 24'h0100, 8'h00, 16'd8);
    run(24'h0A0, 1, 0);
    chk_cmd("R11 implied read", 0, 8'h02, 24'h0, 16'd24, 0);
    chk_cmd("R11 next at 8", 1, 8'h02, 24'h0100, 16'd8, 0);
    chk("R11 no fetch of 0", nrd_zero, 0);
    chk("R11 end", ecode, 0);
  endtask

  task automatic t_busy_start();
    setup();
    mem[0] = w(8'h01, 24'h0A00, F_CC, 16'd1);
    mem[1] = w(8'h03, 24'h0B00, 8'h00, 16'd1);
    mem[24] = w(8'h0E, 24'h0C00, 8'h00, 16'd1);
    run(24'h000, 0, 1);
    chk("R12 count", ncmd, 2);
    chk_cmd("R12 unchanged", 1, 8'h03, 24'h0B00, 16'd1, 0);
    chk("R12 one irq", nirq, 1);
  endtask

  initial begin
    clr = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); clr = 1'b0;
    t_cmd_chain();
    t_data_chain();
    t_tic();
    t_search_loop();
    t_tic_tic();
    t_length();
    t_dev_err();
    t_pci();
    t_ipl();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule